// File: doc/BRIEF.md
# Rotating Register File with Circular Rename Offset

This block is a register file whose logical index space has two parts. Indices below a fixed base map straight to storage. Indices in a window starting at that base form a rotating region, and they reach storage through a circular rename offset. Each rotate pulse moves that offset back by one step. After the pulse, every value held in the region appears one logical index higher, and the value at the top of the window comes back at the base. A loop body can therefore write the same logical name on every iteration, while the values of earlier iterations stay readable under the next-higher names.

The size of the rotating region is set at run time as a count of fixed-size blocks. A count above the largest allowed value is clamped to that maximum. Logical indices at or above the top of the configured window behave like the low region and never move. The entry width is a parameter, so one design covers wide data entries and one-bit flag entries. For a flag file, set the block size to the whole rotating span and allow a single block. The file has two combinational read ports and one write port that acts on the clock edge. An asynchronous active-low reset clears every entry and the rename offset.

Top module: `rot_regfile`

## Requirements
- R1: While reset is asserted, and right after it is released, both read ports return zero for every logical index.
- R2: A logical index below `BASE` always names the same entry. A rotate pulse never changes what it reads.
- R3: With no write in the same cycle, a value readable at logical `BASE+k` is readable at logical `BASE+k+1` after one rotate pulse, for `k` below `size-1`.
- R4: The rotation is circular. After one rotate pulse, the value readable at logical `BASE+size-1` is readable at logical `BASE`.
- R5: The rotating size is `min(rot_blocks, MAX_BLOCKS) * GRAIN` entries. A logical index at or above `BASE+size` is not rotated: a rotate pulse leaves its value in place.
- R6: When a write and a rotate happen in the same cycle, the write uses the mapping from before the rotate. The written value is then readable one logical index higher, with wraparound inside the region.
- R7: Reads are combinational through the current mapping. A write becomes visible on the read ports only after the clock edge that takes it. During the write cycle, the read port returns the old value.
- R8: When the configured size is zero, a rotate pulse has no effect on any logical index.
- R9: After `size` rotate pulses with no writes, every logical index reads its original value again.
- R10: When `wr_en` is low, `wr_addr` and `wr_data` have no effect on any entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronous to `clk` |
| rot_blocks | input | BLK_W | Rotating region size, as a count of `GRAIN`-entry blocks (clamped to `MAX_BLOCKS`) |
| rotate | input | 1 | Rotate strobe; steps the rename offset by one on the clock edge |
| wr_en | input | 1 | Write enable |
| wr_addr | input | AW | Logical write index |
| wr_data | input | DATA_W | Write data |
| rd0_addr | input | AW | Logical index for read port 0 |
| rd0_data | output | DATA_W | Read port 0 data (combinational) |
| rd1_addr | input | AW | Logical index for read port 1 |
| rd1_data | output | DATA_W | Read port 1 data (combinational) |

## Verification
The bound checker checks, on every clock, that the block reads zero during reset. It also checks that low-region values stay put and that a value read before a rotate appears at the next logical index, including the wrap from the top of the window to the base, on whichever read port addresses that index. It further checks that a same-cycle write plus rotate lands one index higher, that a plain write is visible after its edge, and that indices above the window hold through a rotate. The bench scenarios cover what needs a longer history. A full cycle of `size` rotations must return every value to its original name, the clamp of the block count must hold, a zero-sized region must ignore rotate pulses, and a disabled write port must leave every index unchanged. The bench shows these by sweeping every logical index after each step, for every block count of a small configuration.

// File: rtl/rotrf_pkg.sv
`timescale 1ns/1ps
package rotrf_pkg;
  // Width helper that never returns zero, so one-value fields still get a bit.
  function automatic int clog2_min1(input int value);
    return (value < 2) ? 1 : $clog2(value);
  endfunction
endpackage

// File: rtl/rotrf_map.sv
`timescale 1ns/1ps
// Logical-to-physical index translation for one access port.
module rotrf_map #(
  parameter int AW   = 7,
  parameter int BASE = 32
) (
  input  logic [AW-1:0] log_idx,
  input  logic [AW:0]   rot_size,
  input  logic [AW:0]   rrb,
  output logic [AW-1:0] phys_idx
);
  localparam int XW = AW + 2;
  localparam logic [XW-1:0] BASE_X = XW'(BASE);

  logic [XW-1:0] off;
  logic [XW-1:0] size_x;
  logic [XW-1:0] sum;
  logic [XW-1:0] wrapped;
  logic          in_rot;

  always_comb begin
    size_x  = {1'b0, rot_size};
    off     = {2'b00, log_idx} - BASE_X;
    in_rot  = ({2'b00, log_idx} >= BASE_X) && (off < size_x);
    sum     = off + {1'b0, rrb};
    wrapped = (sum >= size_x) ? (sum - size_x) : sum;
    phys_idx = in_rot ? AW'(BASE_X + wrapped) : log_idx;
  end
endmodule

// File: rtl/rotrf_base.sv
`timescale 1ns/1ps
// Rename offset: steps down by one, modulo the region size, on each rotate.
module rotrf_base #(
  parameter int AW = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rotate,
  input  logic [AW:0] rot_size,
  output logic [AW:0] rrb
);
  logic [AW:0] rrb_q;
  logic [AW:0] rrb_d;
  logic        rrb_en;

  always_comb begin
    rrb_en = rotate && (rot_size != '0);
    if ((rrb_q == '0) || (rrb_q >= rot_size)) rrb_d = rot_size - 1'b1;
    else                                      rrb_d = rrb_q - 1'b1;
    rrb = (rrb_q >= rot_size) ? '0 : rrb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rrb_q <= '0;
    else if (rrb_en) rrb_q <= rrb_d;
  end
endmodule

// File: rtl/rotrf_array.sv
`timescale 1ns/1ps
// Physical storage: one write port, two combinational read ports.
module rotrf_array #(
  parameter int NUM_REGS = 128,
  parameter int DATA_W   = 64,
  parameter int AW       = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     w_idx,
  input  logic [DATA_W-1:0] w_data,
  input  logic [AW-1:0]     r0_idx,
  output logic [DATA_W-1:0] r0_data,
  input  logic [AW-1:0]     r1_idx,
  output logic [DATA_W-1:0] r1_data
);
  localparam logic [AW:0] LIMIT = (AW+1)'(NUM_REGS);

  logic [DATA_W-1:0] mem [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
    logic hit;
    assign hit = we && (w_idx == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[g] <= '0;
      else if (hit) mem[g] <= w_data;
    end
  end

  always_comb begin
    r0_data = ({1'b0, r0_idx} < LIMIT) ? mem[r0_idx] : '0;
    r1_data = ({1'b0, r1_idx} < LIMIT) ? mem[r1_idx] : '0;
  end
endmodule

// File: rtl/rot_regfile.sv
`timescale 1ns/1ps
module rot_regfile #(
  parameter int NUM_REGS   = 128,
  parameter int DATA_W     = 64,
  parameter int BASE       = 32,
  parameter int GRAIN      = 8,
  parameter int MAX_BLOCKS = 12,
  localparam int AW        = rotrf_pkg::clog2_min1(NUM_REGS),
  localparam int BLK_W     = rotrf_pkg::clog2_min1(MAX_BLOCKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BLK_W-1:0]  rot_blocks,
  input  logic              rotate,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd0_addr,
  output logic [DATA_W-1:0] rd0_data,
  input  logic [AW-1:0]     rd1_addr,
  output logic [DATA_W-1:0] rd1_data
);
  localparam int NPORT = 3;  // read 0, read 1, write

  logic [BLK_W-1:0] blocks_c;
  logic [AW:0]      rot_size;
  logic [AW:0]      rrb;
  logic [AW-1:0]    log_a  [NPORT];
  logic [AW-1:0]    phys_a [NPORT];

  always_comb begin
    blocks_c = (int'(rot_blocks) > MAX_BLOCKS) ? BLK_W'(MAX_BLOCKS) : rot_blocks;
    rot_size = (AW+1)'(int'(blocks_c) * GRAIN);
  end

  assign log_a[0] = rd0_addr;
  assign log_a[1] = rd1_addr;
  assign log_a[2] = wr_addr;

  rotrf_base #(.AW(AW)) u_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .rotate   (rotate),
    .rot_size (rot_size),
    .rrb      (rrb)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    rotrf_map #(.AW(AW), .BASE(BASE)) u_map (
      .log_idx  (log_a[p]),
      .rot_size (rot_size),
      .rrb      (rrb),
      .phys_idx (phys_a[p])
    );
  end

  rotrf_array #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .AW(AW)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_en),
    .w_idx   (phys_a[2]),
    .w_data  (wr_data),
    .r0_idx  (phys_a[0]),
    .r0_data (rd0_data),
    .r1_idx  (phys_a[1]),
    .r1_data (rd1_data)
  );
endmodule

// File: rtl/rot_regfile_chk.sv
`timescale 1ns/1ps
module rot_regfile_chk #(
  parameter int NUM_REGS   = 128,
  parameter int DATA_W     = 64,
  parameter int BASE       = 32,
  parameter int GRAIN      = 8,
  parameter int MAX_BLOCKS = 12,
  localparam int AW        = rotrf_pkg::clog2_min1(NUM_REGS),
  localparam int BLK_W     = rotrf_pkg::clog2_min1(MAX_BLOCKS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BLK_W-1:0]  rot_blocks,
  input logic              rotate,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [AW-1:0]     rd0_addr,
  input logic [DATA_W-1:0] rd0_data,
  input logic [AW-1:0]     rd1_addr,
  input logic [DATA_W-1:0] rd1_data
);
  int            sz;
  logic          rd0_rot, rd0_top, rd0_above, wr_rot;
  logic [AW-1:0] rd0_next, wr_next;

  function automatic logic [AW-1:0] step_idx(input logic [AW-1:0] a, input int s);
    if (s == 0 || int'(a) < BASE || int'(a) >= BASE + s) return a;
    if (int'(a) == BASE + s - 1) return AW'(BASE);
    return a + 1'b1;
  endfunction

  always_comb begin
    sz        = ((int'(rot_blocks) > MAX_BLOCKS) ? MAX_BLOCKS : int'(rot_blocks)) * GRAIN;
    rd0_rot   = (sz != 0) && int'(rd0_addr) >= BASE && int'(rd0_addr) < BASE + sz;
    rd0_top   = rd0_rot && int'(rd0_addr) == BASE + sz - 1;
    rd0_above = int'(rd0_addr) >= BASE + sz;
    wr_rot    = (sz != 0) && int'(wr_addr) >= BASE && int'(wr_addr) < BASE + sz;
    rd0_next  = step_idx(rd0_addr, sz);
    wr_next   = step_idx(wr_addr, sz);
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |-> (rd0_data == '0 && rd1_data == '0)); // R1
  AST_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (int'(rd0_addr) < BASE && $stable(rd0_addr) && !$past(wr_en)) |-> $stable(rd0_data)); // R2
  AST_ROT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (rotate && !wr_en && rd0_rot && !rd0_top) |=> (!$stable(rot_blocks) || rd1_addr != $past(rd0_next) || rd1_data == $past(rd0_data))); // R3
  AST_ROT_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (rotate && !wr_en && rd0_top) |=> (!$stable(rot_blocks) || rd1_addr != AW'(BASE) || rd1_data == $past(rd0_data))); // R4
  AST_ABOVE_FIXED: assert property (@(posedge clk) disable iff (!rst_n) (rotate && !wr_en && rd0_above) |=> (!$stable(rot_blocks) || rd0_addr != $past(rd0_addr) || rd0_data == $past(rd0_data))); // R5
  AST_WRITE_ROTATE: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && rotate && wr_rot) |=> (!$stable(rot_blocks) || rd0_addr != $past(wr_next) || rd0_data == $past(wr_data))); // R6
  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !rotate) |=> (!$stable(rot_blocks) || rd1_addr != $past(wr_addr) || rd1_data == $past(wr_data))); // R7
endmodule

bind rot_regfile rot_regfile_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .BASE(BASE), .GRAIN(GRAIN), .MAX_BLOCKS(MAX_BLOCKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rot_blocks(rot_blocks), .rotate(rotate),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd0_addr(rd0_addr), .rd0_data(rd0_data), .rd1_addr(rd1_addr), .rd1_data(rd1_data)
);

// File: tb/rot_regfile_bench.sv
`timescale 1ns/1ps
module rot_regfile_bench;
  localparam int NR = 16, DW = 8, BS = 4, GR = 4, MB = 2;
  localparam int AW = 4, BW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [BW-1:0] rot_blocks = '0;
  logic          rotate = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd0_addr = '0, rd1_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd0_data, rd1_data;

  int errors = 0, checks = 0, cur_size = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [NR];

  always #4 clk = ~clk;  // 125 MHz

  rot_regfile #(.NUM_REGS(NR), .DATA_W(DW), .BASE(BS), .GRAIN(GR), .MAX_BLOCKS(MB)) u_rot_regfile (
    .clk(clk), .rst_n(rst_n), .rot_blocks(rot_blocks), .rotate(rotate),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd0_addr(rd0_addr), .rd0_data(rd0_data), .rd1_addr(rd1_addr), .rd1_data(rd1_data)
  );

  task automatic cmp(input string tag, input int a, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s idx=%0d actual=%0h expected=%0h", tag, a, act, exp);
    end
  endtask

  function automatic string tag_of(input int a, input string dflt);
    if (a < BS) return "R2";
    if (a >= BS + cur_size) return "R5";
    if (a == BS && dflt == "R3") return "R4";
    return dflt;
  endfunction

  task automatic sweep(input string t);
    for (int a = 0; a < NR; a++) begin
      rd0_addr = AW'(a);
      rd1_addr = AW'(NR - 1 - a);
      #0.2;
      cmp(tag_of(a, t), a, rd0_data, model[a]);
      cmp(tag_of(NR - 1 - a, t), NR - 1 - a, rd1_data, model[NR - 1 - a]);
    end
  endtask

  task automatic step(input bit we, input int wa, input int wd, input bit rot, input string t);
    logic [DW-1:0] tmp [NR];
    @(negedge clk);
    wr_en = we; wr_addr = AW'(wa); wr_data = DW'(wd); rotate = rot;
    rd0_addr = AW'(wa);
    #0.5;
    if (we) cmp("R7", wa, rd0_data, model[wa]);  // old value before the edge
    @(posedge clk);
    if (we) model[wa] = DW'(wd);
    if (rot && cur_size > 0) begin
      for (int i = 0; i < NR; i++) tmp[i] = model[i];
      for (int j = 0; j < cur_size; j++) model[BS + ((j + 1) % cur_size)] = tmp[BS + j];
    end
    #1;
    wr_en = 1'b0; rotate = 1'b0;
    sweep(t);
  endtask

  task automatic do_reset(input int cfg);
    @(negedge clk);
    rst_n = 1'b0; rot_blocks = BW'(cfg); wr_en = 1'b0; rotate = 1'b0;
    for (int i = 0; i < NR; i++) model[i] = '0;
    cur_size = ((cfg > MB) ? MB : cfg) * GR;
    #1;
    sweep("R1");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    for (int cfg = 0; cfg < 4; cfg++) begin
      do_reset(cfg);
      sweep("R1");
      for (int a = 0; a < NR; a++) step(1'b1, a, cfg * 40 + a + 1, 1'b0, "R7");
      // full circle of rotations returns the original mapping (R9)
      for (int n = 0; n < cur_size; n++) step(1'b0, 0, 0, 1'b1, (cur_size == 0) ? "R8" : "R3");
      for (int a = 0; a < NR; a++) cmp("R9", a, model[a], DW'(cfg * 40 + a + 1));
      step(1'b0, 0, 0, 1'b1, (cur_size == 0) ? "R8" : "R3");
      step(1'b0, 0, 0, 1'b1, (cur_size == 0) ? "R8" : "R3");
      step(1'b0, BS, 8'hA5, 1'b0, "R10");
      step(1'b0, NR - 1, 8'h5A, 1'b0, "R10");
      for (int t = 0; t < 48; t++) begin
        bit we, rot;
        we  = (t % 3) != 0;
        rot = (t % 2) == 0;
        step(we, (t * 7 + 3) % NR, cfg * 50 + t * 3 + 9, rot,
             (we && rot) ? "R6" : (rot ? ((cur_size == 0) ? "R8" : "R3") : "R7"));
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule